// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a compact in-order integer core split into five overlapped stages: fetch, decode with register read, execute (ALU and address or branch-target arithmetic), memory access, and write-back. Four inter-stage registers sit between the five stages. Every value that a later stage needs travels through them. Past write-back there is no further register, because results land in the register file.

The core runs a small integer subset: register-register add and subtract, word load, word store and branch-if-equal. Instruction fetch uses a word-wide read port with a combinational return path. Data access uses one address, one write-data bus, a write strobe, and a read-data input that is also combinational. Operand forwarding, a one-cycle load-use interlock and a three-slot flush on a taken branch keep results correct without help from software.

Top module: `pipe5_core`

## Requirements
- R1: When no hazard occurs, one instruction enters fetch on every cycle and one completes on every cycle. A store at address 0 after reset drives its write strobe in the cycle after the third rising edge following reset release. Consecutive stores strobe on consecutive cycles.
- R2: While reset is high, the fetch address is RESET_PC (default 0), every inter-stage register holds a bubble, and the data write strobe stays low.
- R3: Encodings and field positions are as follows. op is bits [31:26], rs is [25:21], rt is [20:16], rd is [15:11], func is [5:0] and imm is [15:0]. With op 0x00, func 0x20 gives rd=rs+rt and func 0x22 gives rd=rs-rt. op 0x23 loads a word into rt. op 0x2B stores rt. op 0x04 is the equality branch. Any other op or func value acts as a no-op.
- R4: The load and store address is rs plus imm, with imm sign-extended from bit 15.
- R5: When an instruction reads a register that the load directly ahead of it writes, the core stalls once. The PC and the fetch/decode register hold, and a bubble enters decode/execute. The dependent instruction sees the loaded value.
- R6: ALU and store-data operands are forwarded from execute/memory and from memory/write-back. When both hold the register, the younger producer wins.
- R7: Register 0 always reads as zero. Writes to it are dropped, and it is never a forwarding source.
- R8: A branch-if-equal whose operands match is resolved in the memory stage. The next PC becomes PC+4 plus imm shifted left by 2, and the three younger instructions are squashed so that they have no effect.
- R9: A branch-if-equal whose operands differ continues with the sequential instruction.
- R10: A register written back in a given cycle is seen by a decode-stage read in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address for a data load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Data write strobe |
| dmem_rdata | input | 32 | Data word at dmem_addr, same cycle |

## Verification
On every cycle, the bound properties check how the PC steps: by four normally, not at all during a load-use stall, and to the captured target after a taken branch. They also check that a stall puts a bubble into decode/execute, that a taken branch empties the three younger slots, and that reset leaves the pipeline empty. Arithmetic results, forwarding priority, the handling of register 0, same-cycle write-then-read, sign-extended addressing and the squashing of wrong-path stores can only be seen in the data memory image. The bench scenarios therefore run short programs over sweeps of operand values and compare the stored words with sums and differences that the bench computes itself.

// File: rtl/p5_pkg.sv
package p5_pkg;

    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);

    typedef enum logic [5:0] {
        OP_ALU   = 6'h00,
        OP_BEQ   = 6'h04,
        OP_LOAD  = 6'h23,
        OP_STORE = 6'h2B
    } opcode_e;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;

    typedef enum logic [1:0] {
        FW_REG = 2'd0,
        FW_MEM = 2'd1,
        FW_WB  = 2'd2
    } fwd_e;

    // decoded control for one instruction
    typedef struct packed {
        logic              wr_reg;
        logic              rd_mem;
        logic              wr_mem;
        logic              is_br;
        logic              imm_b;
        logic              sub;
        logic              use_rs;
        logic              use_rt;
        logic [RIDX_W-1:0] dst;
    } ctl_t;

    typedef struct packed {
        logic            valid;
        logic [31:0]     ins;
        logic [XLEN-1:0] pc4;
    } ifid_t;

    typedef struct packed {
        logic              wr_reg;
        logic              rd_mem;
        logic              wr_mem;
        logic              is_br;
        logic              imm_b;
        logic              sub;
        logic [RIDX_W-1:0] dst;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [XLEN-1:0]   a;
        logic [XLEN-1:0]   b;
        logic [XLEN-1:0]   imm;
        logic [XLEN-1:0]   pc4;
    } idex_t;

    typedef struct packed {
        logic              wr_reg;
        logic              rd_mem;
        logic              wr_mem;
        logic              is_br;
        logic [RIDX_W-1:0] dst;
        logic [XLEN-1:0]   alu;
        logic [XLEN-1:0]   sdata;
        logic [XLEN-1:0]   tgt;
        logic              eq;
    } exmem_t;

    typedef struct packed {
        logic              wr_reg;
        logic              rd_mem;
        logic [RIDX_W-1:0] dst;
        logic [XLEN-1:0]   alu;
        logic [XLEN-1:0]   ldata;
    } memwb_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic ctl_t decode(input logic [31:0] ins);
        ctl_t c;
        c = '0;
        case (opcode_e'(ins[31:26]))
            OP_ALU: begin
                if (ins[5:0] == FN_ADD || ins[5:0] == FN_SUB) begin
                    c.wr_reg = 1'b1;
                    c.use_rs = 1'b1;
                    c.use_rt = 1'b1;
                    c.sub    = (ins[5:0] == FN_SUB);
                    c.dst    = ins[15:11];
                end
            end
            OP_LOAD: begin
                c.wr_reg = 1'b1;
                c.rd_mem = 1'b1;
                c.imm_b  = 1'b1;
                c.use_rs = 1'b1;
                c.dst    = ins[20:16];
            end
            OP_STORE: begin
                c.wr_mem = 1'b1;
                c.imm_b  = 1'b1;
                c.use_rs = 1'b1;
                c.use_rt = 1'b1;
            end
            OP_BEQ: begin
                c.is_br  = 1'b1;
                c.use_rs = 1'b1;
                c.use_rt = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/p5_regfile.sv
module p5_regfile #(
    parameter  int W  = 32,
    parameter  int N  = 32,
    localparam int AW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [AW-1:0]        wa,
    input  logic [W-1:0]         wd,
    input  logic [1:0][AW-1:0]   ra,
    output logic [1:0][W-1:0]    rd
);

    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (we && wa != '0) regs[wa] <= wd;
    end

    // write-first read ports; index 0 is hard zero
    for (genvar p = 0; p < 2; p++) begin : g_rd
        always_comb begin
            if (ra[p] == '0)
                rd[p] = '0;
            else if (we && wa == ra[p])
                rd[p] = wd;
            else
                rd[p] = regs[ra[p]];
        end
    end

endmodule

// File: rtl/p5_alu.sv
module p5_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);

    always_comb y = sub ? (a - b) : (a + b);

endmodule

// File: rtl/p5_hazard.sv
module p5_hazard
    import p5_pkg::*;
(
    input  logic              id_use_rs,
    input  logic              id_use_rt,
    input  logic [RIDX_W-1:0] id_rs,
    input  logic [RIDX_W-1:0] id_rt,
    input  logic              ex_ld,
    input  logic [RIDX_W-1:0] ex_dst,
    input  logic [RIDX_W-1:0] ex_rs,
    input  logic [RIDX_W-1:0] ex_rt,
    input  logic              mem_fw,
    input  logic [RIDX_W-1:0] mem_dst,
    input  logic              wb_wr,
    input  logic [RIDX_W-1:0] wb_dst,
    output logic              stall,
    output fwd_e              fwd_a,
    output fwd_e              fwd_b
);

    logic [1:0][RIDX_W-1:0] src;
    fwd_e [1:0]             sel;

    assign src = {ex_rt, ex_rs};

    always_comb begin
        stall = ex_ld && (ex_dst != '0) &&
                ((id_use_rs && id_rs == ex_dst) || (id_use_rt && id_rt == ex_dst));
    end

    // younger producer (execute/memory) checked first
    for (genvar k = 0; k < 2; k++) begin : g_fwd
        always_comb begin
            if (mem_fw && mem_dst != '0 && mem_dst == src[k])
                sel[k] = FW_MEM;
            else if (wb_wr && wb_dst != '0 && wb_dst == src[k])
                sel[k] = FW_WB;
            else
                sel[k] = FW_REG;
        end
    end

    assign fwd_a = sel[0];
    assign fwd_b = sel[1];

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import p5_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [31:0]     imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] pc_q;
    ifid_t           ifid_q;
    idex_t           idex_q;
    exmem_t          exmem_q;
    memwb_t          memwb_q;

    logic            ld_stall;
    logic            br_taken;
    fwd_e            fwd_a, fwd_b;

    // ---------------- fetch ----------------
    logic [XLEN-1:0] pc_plus4;
    assign pc_plus4  = pc_q + STEP;
    assign imem_addr = pc_q;

    // ---------------- decode ----------------
    ctl_t                   id_ctl;
    logic [RIDX_W-1:0]      id_rs, id_rt;
    logic [1:0][XLEN-1:0]   rf_rd;
    logic [XLEN-1:0]        wb_val;

    assign id_ctl = ifid_q.valid ? decode(ifid_q.ins) : '0;
    assign id_rs  = ifid_q.ins[25:21];
    assign id_rt  = ifid_q.ins[20:16];

    p5_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk (clk),
        .we  (memwb_q.wr_reg),
        .wa  (memwb_q.dst),
        .wd  (wb_val),
        .ra  ({id_rt, id_rs}),
        .rd  (rf_rd)
    );

    p5_hazard u_hz (
        .id_use_rs (id_ctl.use_rs),
        .id_use_rt (id_ctl.use_rt),
        .id_rs     (id_rs),
        .id_rt     (id_rt),
        .ex_ld     (idex_q.rd_mem),
        .ex_dst    (idex_q.dst),
        .ex_rs     (idex_q.rs),
        .ex_rt     (idex_q.rt),
        .mem_fw    (exmem_q.wr_reg && !exmem_q.rd_mem),
        .mem_dst   (exmem_q.dst),
        .wb_wr     (memwb_q.wr_reg),
        .wb_dst    (memwb_q.dst),
        .stall     (ld_stall),
        .fwd_a     (fwd_a),
        .fwd_b     (fwd_b)
    );

    // ---------------- execute ----------------
    logic [XLEN-1:0] op_a, op_b_reg, op_b, alu_y, br_tgt;

    always_comb begin
        case (fwd_a)
            FW_MEM:  op_a = exmem_q.alu;
            FW_WB:   op_a = wb_val;
            default: op_a = idex_q.a;
        endcase
        case (fwd_b)
            FW_MEM:  op_b_reg = exmem_q.alu;
            FW_WB:   op_b_reg = wb_val;
            default: op_b_reg = idex_q.b;
        endcase
    end

    assign op_b   = idex_q.imm_b ? idex_q.imm : op_b_reg;
    assign br_tgt = idex_q.pc4 + {idex_q.imm[XLEN-3:0], 2'b00};

    p5_alu #(.W(XLEN)) u_alu (
        .a   (op_a),
        .b   (op_b),
        .sub (idex_q.sub),
        .y   (alu_y)
    );

    // ---------------- memory ----------------
    assign br_taken   = exmem_q.is_br && exmem_q.eq;
    assign dmem_addr  = exmem_q.alu;
    assign dmem_wdata = exmem_q.sdata;
    assign dmem_we    = exmem_q.wr_mem;

    // ---------------- write-back ----------------
    assign wb_val = memwb_q.rd_mem ? memwb_q.ldata : memwb_q.alu;

    // ---------------- state ----------------
    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= RESET_PC;
        else if (br_taken)
            pc_q <= exmem_q.tgt;
        else if (!ld_stall)
            pc_q <= pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst || br_taken)
            ifid_q <= '0;
        else if (!ld_stall)
            ifid_q <= '{valid: 1'b1, ins: imem_rdata, pc4: pc_plus4};
    end

    always_ff @(posedge clk) begin
        if (rst || br_taken || ld_stall)
            idex_q <= '0;
        else
            idex_q <= '{wr_reg: id_ctl.wr_reg, rd_mem: id_ctl.rd_mem,
                        wr_mem: id_ctl.wr_mem, is_br: id_ctl.is_br,
                        imm_b: id_ctl.imm_b, sub: id_ctl.sub, dst: id_ctl.dst,
                        rs: id_rs, rt: id_rt, a: rf_rd[0], b: rf_rd[1],
                        imm: sext16(ifid_q.ins[15:0]), pc4: ifid_q.pc4};
    end

    always_ff @(posedge clk) begin
        if (rst || br_taken)
            exmem_q <= '0;
        else
            exmem_q <= '{wr_reg: idex_q.wr_reg, rd_mem: idex_q.rd_mem,
                         wr_mem: idex_q.wr_mem, is_br: idex_q.is_br,
                         dst: idex_q.dst, alu: alu_y, sdata: op_b_reg,
                         tgt: br_tgt, eq: (op_a == op_b_reg)};
    end

    always_ff @(posedge clk) begin
        if (rst)
            memwb_q <= '0;
        else
            memwb_q <= '{wr_reg: exmem_q.wr_reg, rd_mem: exmem_q.rd_mem,
                         dst: exmem_q.dst, alu: exmem_q.alu, ldata: dmem_rdata};
    end

endmodule

// File: rtl/p5_core_chk.sv
module p5_core_chk
    import p5_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc,
    input logic            stall,
    input logic            taken,
    input logic [XLEN-1:0] tgt,
    input ifid_t           ifid,
    input logic            idex_live,
    input logic            exmem_live,
    input logic            dmem_we
);

    // R2
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pc == RESET_PC) && !ifid.valid && !idex_live && !exmem_live && !dmem_we);

    // R1
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && !taken) |=> (pc == $past(pc) + XLEN'(4)));

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stall && !taken) |=> ($stable(pc) && $stable(ifid)));

    // R5
    stall_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        (stall && !taken) |=> !idex_live);

    // R8
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        taken |=> (!ifid.valid && !idex_live && !exmem_live));

    // R8
    redirect_chk: assert property (@(posedge clk) disable iff (rst)
        taken |=> (pc == $past(tgt)));

endmodule

bind pipe5_core p5_core_chk #(.RESET_PC(RESET_PC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc         (pc_q),
    .stall      (ld_stall),
    .taken      (br_taken),
    .tgt        (exmem_q.tgt),
    .ifid       (ifid_q),
    .idex_live  (idex_q.wr_reg | idex_q.rd_mem | idex_q.wr_mem | idex_q.is_br),
    .exmem_live (exmem_q.wr_reg | exmem_q.rd_mem | exmem_q.wr_mem | exmem_q.is_br),
    .dmem_we    (dmem_we)
);

// File: tb/pipe5_core_tb.sv
module pipe5_core_tb;

    localparam logic [5:0] T_ALU = 6'h00, T_BEQ = 6'h04, T_LW = 6'h23, T_SW = 6'h2B;
    localparam logic [5:0] T_ADD = 6'h20, T_SUB = 6'h22;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    pipe5_core u_dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (!rst && dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {T_ALU, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'h0;
            dmem[i] = SENT;
        end
    endtask

    task automatic start();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(int cycles);
        start();
        repeat (cycles) @(posedge clk);
        @(negedge clk);
    endtask

    logic [31:0] vals [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                              32'h8000_0000, 32'h1234_5678};
    logic [31:0] xs [6]   = '{32'h1234_5678, 32'h1, 32'hFFFF_FFFF, 32'h8000_0001,
                              32'h7FFF_FFFF, 32'hA5A5_A5A5};

    initial begin
        int first_we, last_we, cnt_we;

        // ---------- reset state and throughput ----------
        clear_mem();
        for (int k = 0; k < 8; k++) imem[k] = enc_i(T_SW, 0, 0, 16'(80 + 4*k));
        imem[8] = enc_i(T_BEQ, 0, 0, 16'hFFFF);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R2 fetch address in reset", imem_addr, 32'h0);
        chk("R2 write strobe in reset", {31'b0, dmem_we}, 32'h0);
        rst = 1'b0;
        first_we = -1; last_we = -1; cnt_we = 0;
        for (int i = 1; i <= 16; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (dmem_we) begin
                if (first_we < 0) first_we = i;
                last_we = i;
                cnt_we++;
            end
        end
        chk("R1 first store strobe edge", 32'(first_we), 32'd3);
        chk("R1 last store strobe edge", 32'(last_we), 32'd10);
        chk("R1 store count", 32'(cnt_we), 32'd8);
        for (int k = 0; k < 8; k++)
            chk("R7 store of register 0", dmem[20+k], 32'h0);

        // ---------- arithmetic, load-use, forwarding, write-first ----------
        foreach (vals[i]) begin
            foreach (vals[j]) begin
                clear_mem();
                dmem[0] = vals[i];
                dmem[1] = vals[j];
                imem[0] = enc_i(T_LW, 0, 1, 16'd0);
                imem[1] = enc_i(T_LW, 0, 2, 16'd4);
                imem[2] = enc_r(1, 2, 3, T_ADD);
                imem[3] = enc_r(1, 2, 4, T_SUB);
                imem[4] = enc_r(3, 4, 5, T_ADD);
                imem[5] = enc_i(T_SW, 0, 3, 16'd8);
                imem[6] = enc_i(T_SW, 0, 4, 16'd12);
                imem[7] = enc_i(T_SW, 0, 5, 16'd16);
                imem[8] = enc_i(T_BEQ, 0, 0, 16'hFFFF);
                run(40);
                chk("R5 R10 R3 add after load", dmem[2], vals[i] + vals[j]);
                chk("R3 R10 sub", dmem[3], vals[i] - vals[j]);
                chk("R6 forwarded add", dmem[4], vals[i] + vals[i]);
            end
        end

        // ---------- register 0, no-op, priority, branches, sign extension ----------
        foreach (xs[i]) begin
            clear_mem();
            dmem[0]  = xs[i];
            dmem[1]  = 32'd64;
            dmem[14] = ~xs[i];
            imem[0]  = enc_i(T_LW, 0, 1, 16'd0);
            imem[1]  = enc_r(1, 1, 0, T_ADD);
            imem[2]  = enc_r(1, 0, 2, T_ADD);
            imem[3]  = enc_i(6'h3F, 1, 2, 16'h1000);
            imem[4]  = enc_i(T_SW, 0, 2, 16'd32);
            imem[5]  = enc_r(1, 1, 3, T_SUB);
            imem[6]  = enc_r(1, 1, 3, T_ADD);
            imem[7]  = enc_r(3, 0, 4, T_ADD);
            imem[8]  = enc_i(T_SW, 0, 4, 16'd36);
            imem[9]  = enc_i(T_BEQ, 1, 2, 16'd3);
            imem[10] = enc_i(T_SW, 0, 1, 16'd40);
            imem[11] = enc_i(T_SW, 0, 1, 16'd44);
            imem[12] = enc_i(T_SW, 0, 1, 16'd48);
            imem[13] = enc_i(T_BEQ, 1, 3, 16'd2);
            imem[14] = enc_i(T_SW, 0, 1, 16'd52);
            imem[15] = enc_i(T_LW, 0, 6, 16'd4);
            imem[16] = enc_i(T_LW, 6, 7, 16'hFFF8);
            imem[17] = enc_i(T_SW, 0, 7, 16'd60);
            imem[18] = enc_i(T_BEQ, 0, 0, 16'hFFFF);
            run(70);
            chk("R7 R3 register 0 and no-op", dmem[8], xs[i]);
            chk("R6 younger producer wins", dmem[9], xs[i] + xs[i]);
            chk("R8 squashed slot 1", dmem[10], SENT);
            chk("R8 squashed slot 2", dmem[11], SENT);
            chk("R8 squashed slot 3", dmem[12], SENT);
            chk("R9 fall-through store", dmem[13], xs[i]);
            chk("R4 R5 negative offset load", dmem[15], ~xs[i]);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule